// File: doc/BRIEF.md
# Configurable-Edge External Interrupt Controller

The controller watches 96 external input lines, grouped as three banks of 32. Global line n belongs to bank n/32 at bit n%32. Every line first passes through a two-flop synchroniser. For an ordinary line, software selects detection of rising edges, falling edges or both. A detected rising edge sets the line's bit in the bank's rising-pending register. A detected falling edge sets the bit in the falling-pending register. Software can also raise a pending flag directly through a trigger register.

A line is pending while either of its pending bits is set. Its level-high interrupt output is asserted while the line is pending and its interrupt-mask bit is 1. A separate event mask turns every detected edge into a pulse that lasts one clock cycle. The interrupt mask has no effect on these pulses.

A parameter marks some lines as direct. A direct line has no edge selection and no pending state. Its interrupt output simply follows the synchronised input. Software reaches all registers through a plain write strobe, an 8-bit byte address and a 32-bit data word. Reads are combinational from the address.

Top module: `exti_ctrl`

## Requirements
- R1: Bank k (k = 0, 1, 2) places its registers at these byte offsets:
  - rising select at 0x00+0x20k, falling select at 0x04+0x20k, trigger at 0x08+0x20k;
  - rising pending at 0x0C+0x20k, falling pending at 0x10+0x20k;
  - interrupt mask at 0x80+0x10k, event mask at 0x84+0x10k.
  The select and mask registers read back the last value written, with direct-line bits reading 0 in the select registers.
- R2: A synchronous active-high reset clears every register to 0. After reset all interrupt and event outputs are 0.
- R3: A line with only its rising-select bit set records a rising input edge in the rising-pending register. A falling edge on that line changes neither pending register. The pending bit is set on the third rising clock edge after the input changes: two synchroniser stages, then the pending register.
- R4: A line with only its falling-select bit set records falling edges in the falling-pending register, and rising edges are not recorded. With both select bits set, a rising edge sets the rising-pending bit and a falling edge sets the falling-pending bit.
- R5: Writing a 1 to a bit of a pending register clears that bit. Bits written as 0 keep their value. Pending bits stay set until they are cleared.
- R6: When an edge is detected in the same cycle as a write that clears its pending bit, the edge wins and the bit ends up set.
- R7: Writing a 1 to a bit of the trigger register sets that line's rising-pending bit. The trigger offset always reads 0.
- R8: Each bit of `irq_out` for an ordinary line is 1 exactly while that line has a pending bit set and its interrupt-mask bit is 1. Changing the mask changes the output from the next clock edge on, without touching the pending state.
- R9: While a line's event-mask bit is 1, each detected edge gives a pulse on `evt_out` one cycle long, aligned with the pending update. No pulse is produced while the event-mask bit is 0, and the interrupt mask has no effect on pulses.
- R10: The default direct lines are 19, 21 to 25, 30, 47, 54, 61 and 70. For a direct line:
  - `irq_out` follows the input two clock edges after it changes, whatever the mask;
  - its pending bits stay 0, even after a trigger write;
  - its select bits read 0.
- R11: Reading an unmapped offset returns 0, and writing one changes no register. Unmapped offsets are 0x14 to 0x1F of each bank, 0x60 to 0x7F, the mask-region offsets other than 0x0 and 0x4, and 0xB0 and up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_in | input | 96 | Asynchronous external lines, bit n is global line n |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, 0 when unmapped |
| irq_out | output | 96 | Level-high interrupt per line |
| evt_out | output | 96 | One-cycle event pulse per line |

## Verification
The checks drive a line under each edge-select setting:
- rising only, which tells the two pending registers apart and shows a falling edge is ignored;
- falling only, which shows a rising edge is ignored;
- both edges, which shows each edge lands in its own register.

Further checks cover these cases:
- Software triggers and masking are checked against pending state that is already known.
- Event pulses are sampled in the cycle they are due and in the cycle after, so both their timing and their single-cycle length are exercised.
- A direct line is sampled one and two edges after its input changes, which tells a pass-through from a pending path.
- An edge that coincides with a clear write shows which of the two has priority.
- Writes to unmapped offsets show that they do not alias onto real registers.

// File: rtl/exti_pkg.sv
`timescale 1ns/1ps
package exti_pkg;

    localparam int unsigned LINES_PER_BANK = 32;
    localparam int unsigned NUM_BANKS      = 3;
    localparam int unsigned NUM_LINES      = LINES_PER_BANK * NUM_BANKS;
    localparam int unsigned ADDR_W         = 8;
    localparam int unsigned DATA_W         = LINES_PER_BANK;
    localparam int unsigned BANK_W         = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    // Address layout: edge/pending group strided per bank, mask group strided separately.
    localparam int unsigned TRIG_STRIDE = 32;
    localparam int unsigned MASK_BASE   = 128;
    localparam int unsigned MASK_STRIDE = 16;

    // Lines 19, 21..25, 30, 47, 54, 61, 70 pass straight through.
    localparam logic [NUM_LINES-1:0] DEFAULT_DIRECT = 96'h00000040_20408000_43E80000;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_RSEL,
        REG_FSEL,
        REG_SWT,
        REG_RPND,
        REG_FPND,
        REG_IMSK,
        REG_EMSK
    } reg_kind_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        reg_kind_e         kind;
    } reg_sel_t;

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] addr);
        reg_sel_t    s;
        int unsigned a;
        int unsigned off;
        a      = int'(addr);
        s.kind = REG_NONE;
        s.bank = '0;
        if (a < TRIG_STRIDE * NUM_BANKS) begin
            s.bank = BANK_W'(a / TRIG_STRIDE);
            off    = a % TRIG_STRIDE;
            case (off)
                0:       s.kind = REG_RSEL;
                4:       s.kind = REG_FSEL;
                8:       s.kind = REG_SWT;
                12:      s.kind = REG_RPND;
                16:      s.kind = REG_FPND;
                default: s.kind = REG_NONE;
            endcase
        end else if (a >= MASK_BASE && a < MASK_BASE + MASK_STRIDE * NUM_BANKS) begin
            s.bank = BANK_W'((a - MASK_BASE) / MASK_STRIDE);
            off    = (a - MASK_BASE) % MASK_STRIDE;
            case (off)
                0:       s.kind = REG_IMSK;
                4:       s.kind = REG_EMSK;
                default: s.kind = REG_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/exti_sync.sv
`timescale 1ns/1ps
module exti_sync #(
    parameter int unsigned WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/exti_bank.sv
`timescale 1ns/1ps
module exti_bank
    import exti_pkg::*;
#(
    parameter logic [LINES_PER_BANK-1:0] DIRECT = '0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [LINES_PER_BANK-1:0] line_s,
    input  logic                      wr_en,
    input  reg_kind_e                 wr_kind,
    input  logic [LINES_PER_BANK-1:0] wr_data,
    output logic [LINES_PER_BANK-1:0] rsel_q,
    output logic [LINES_PER_BANK-1:0] fsel_q,
    output logic [LINES_PER_BANK-1:0] rpnd_q,
    output logic [LINES_PER_BANK-1:0] fpnd_q,
    output logic [LINES_PER_BANK-1:0] imsk_q,
    output logic [LINES_PER_BANK-1:0] emsk_q,
    output logic [LINES_PER_BANK-1:0] irq,
    output logic [LINES_PER_BANK-1:0] evt
);

    localparam int unsigned W = LINES_PER_BANK;
    localparam logic [W-1:0] EDGE_OK = ~DIRECT;

    logic [W-1:0] prev_q;
    logic [W-1:0] rise_det;
    logic [W-1:0] fall_det;
    logic [W-1:0] swt_set;
    logic [W-1:0] rclr;
    logic [W-1:0] fclr;

    assign rise_det = line_s & ~prev_q & rsel_q;
    assign fall_det = ~line_s & prev_q & fsel_q;
    assign swt_set  = (wr_en && wr_kind == REG_SWT)  ? (wr_data & EDGE_OK) : '0;
    assign rclr     = (wr_en && wr_kind == REG_RPND) ? wr_data : '0;
    assign fclr     = (wr_en && wr_kind == REG_FPND) ? wr_data : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            rsel_q <= '0;
            fsel_q <= '0;
            rpnd_q <= '0;
            fpnd_q <= '0;
            imsk_q <= '0;
            emsk_q <= '0;
            evt    <= '0;
        end else begin
            prev_q <= line_s;
            if (wr_en && wr_kind == REG_RSEL) rsel_q <= wr_data & EDGE_OK;
            if (wr_en && wr_kind == REG_FSEL) fsel_q <= wr_data & EDGE_OK;
            if (wr_en && wr_kind == REG_IMSK) imsk_q <= wr_data;
            if (wr_en && wr_kind == REG_EMSK) emsk_q <= wr_data;
            // set terms are ORed after the clear, so a same-cycle edge wins
            rpnd_q <= ((rpnd_q & ~rclr) | rise_det | swt_set) & EDGE_OK;
            fpnd_q <= ((fpnd_q & ~fclr) | fall_det) & EDGE_OK;
            evt    <= (rise_det | fall_det) & emsk_q;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_line
        if (DIRECT[i]) begin : g_direct
            assign irq[i] = line_s[i];
        end else begin : g_edge
            assign irq[i] = (rpnd_q[i] | fpnd_q[i]) & imsk_q[i];
        end
    end

    AST_RISE_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
        (|rise_det) |=> ((rpnd_q & $past(rise_det)) == $past(rise_det))); // R3

    AST_FALL_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
        (|fall_det) |=> ((fpnd_q & $past(fall_det)) == $past(fall_det))); // R4

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (|rclr) |=> ((rpnd_q & $past(rclr) & ~$past(rise_det | swt_set)) == '0)); // R5

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
        (rclr == '0) |=> (($past(rpnd_q) & ~rpnd_q) == '0)); // R5

    AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ((rclr & rise_det) != '0) |=> ((rpnd_q & $past(rclr & rise_det)) == $past(rclr & rise_det))); // R6

    AST_SWT_SETS: assert property (@(posedge clk) disable iff (rst)
        (|swt_set) |=> ((rpnd_q & $past(swt_set)) == $past(swt_set))); // R7

    AST_EVT_GATED: assert property (@(posedge clk) disable iff (rst)
        (|evt) |-> ((evt & ~$past(emsk_q)) == '0)); // R9

endmodule

// File: rtl/exti_ctrl.sv
`timescale 1ns/1ps
module exti_ctrl
    import exti_pkg::*;
#(
    parameter logic [NUM_LINES-1:0] DIRECT_LINES = DEFAULT_DIRECT
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] ext_in,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_LINES-1:0] irq_out,
    output logic [NUM_LINES-1:0] evt_out
);

    reg_sel_t sel;
    logic [NUM_LINES-1:0] line_sync;

    logic [NUM_BANKS-1:0][DATA_W-1:0] rsel_w;
    logic [NUM_BANKS-1:0][DATA_W-1:0] fsel_w;
    logic [NUM_BANKS-1:0][DATA_W-1:0] rpnd_w;
    logic [NUM_BANKS-1:0][DATA_W-1:0] fpnd_w;
    logic [NUM_BANKS-1:0][DATA_W-1:0] imsk_w;
    logic [NUM_BANKS-1:0][DATA_W-1:0] emsk_w;

    assign sel = decode_addr(bus_addr);

    exti_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ext_in),
        .q   (line_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_we;
        assign bank_we = bus_we && (sel.kind != REG_NONE) && (sel.bank == BANK_W'(b));

        exti_bank #(
            .DIRECT(DIRECT_LINES[b*LINES_PER_BANK +: LINES_PER_BANK])
        ) u_bank (
            .clk     (clk),
            .rst     (rst),
            .line_s  (line_sync[b*LINES_PER_BANK +: LINES_PER_BANK]),
            .wr_en   (bank_we),
            .wr_kind (sel.kind),
            .wr_data (bus_wdata),
            .rsel_q  (rsel_w[b]),
            .fsel_q  (fsel_w[b]),
            .rpnd_q  (rpnd_w[b]),
            .fpnd_q  (fpnd_w[b]),
            .imsk_q  (imsk_w[b]),
            .emsk_q  (emsk_w[b]),
            .irq     (irq_out[b*LINES_PER_BANK +: LINES_PER_BANK]),
            .evt     (evt_out[b*LINES_PER_BANK +: LINES_PER_BANK])
        );
    end

    always_comb begin
        bus_rdata = '0;
        case (sel.kind)
            REG_RSEL: bus_rdata = rsel_w[sel.bank];
            REG_FSEL: bus_rdata = fsel_w[sel.bank];
            REG_RPND: bus_rdata = rpnd_w[sel.bank];
            REG_FPND: bus_rdata = fpnd_w[sel.bank];
            REG_IMSK: bus_rdata = imsk_w[sel.bank];
            REG_EMSK: bus_rdata = emsk_w[sel.bank];
            default:  bus_rdata = '0;
        endcase
    end

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (sel.kind == REG_NONE) |-> (bus_rdata == '0)); // R11

endmodule

// File: tb/exti_ctrl_test.sv
`timescale 1ns/1ps
module exti_ctrl_test;
    import exti_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NUM_LINES-1:0] ext_in = '0;
    logic                 bus_we = 1'b0;
    logic [7:0]           bus_addr = '0;
    logic [31:0]          bus_wdata = '0;
    logic [31:0]          bus_rdata;
    logic [NUM_LINES-1:0] irq_out;
    logic [NUM_LINES-1:0] evt_out;

    always #2 clk = ~clk;

    exti_ctrl uut (
        .clk       (clk),
        .rst       (rst),
        .ext_in    (ext_in),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out),
        .evt_out   (evt_out)
    );

    typedef enum {SRC_RDATA, SRC_IRQ, SRC_EVT} src_e;
    typedef struct {
        src_e        src;
        int          word;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    event  mon_ev;
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 0;

    // monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            @(mon_ev);
            #1;
            while (sb_q.size() > 0) begin
                item_t       it;
                logic [31:0] act;
                it = sb_q.pop_front();
                case (it.src)
                    SRC_IRQ: act = irq_out[it.word*32 +: 32];
                    SRC_EVT: act = evt_out[it.word*32 +: 32];
                    default: act = bus_rdata;
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic push(input src_e s, input int w, input logic [31:0] e, input string tag);
        item_t it;
        it.src  = s;
        it.word = w;
        it.exp  = e;
        it.tag  = tag;
        sb_q.push_back(it);
        -> mon_ev;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_addr = a;
        push(SRC_RDATA, 0, e, tag);
    endtask

    task automatic wait_edges(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R2: reset state
        rd(8'h00, 32'h0, "R2 rising select after reset");
        rd(8'h0C, 32'h0, "R2 rising pending after reset");
        rd(8'h80, 32'h0, "R2 interrupt mask after reset");
        push(SRC_IRQ, 0, 32'h0, "R2 irq word0 after reset");
        push(SRC_IRQ, 2, 32'h0, "R2 irq word2 after reset");
        push(SRC_EVT, 0, 32'h0, "R2 evt word0 after reset");

        // R1: placement and readback
        wr(8'h00, 32'h0000FFFF);
        rd(8'h00, 32'h0000FFFF, "R1 bank0 rising select");
        wr(8'h44, 32'h00000F00);
        rd(8'h44, 32'h00000F00, "R1 bank2 falling select");
        wr(8'h20, 32'h1);
        wr(8'h24, 32'h1);
        rd(8'h24, 32'h1, "R1 bank1 falling select");
        wr(8'hA4, 32'h3);
        rd(8'hA4, 32'h3, "R1 bank2 event mask");
        rd(8'h84, 32'h0, "R1 bank0 event mask untouched");
        wr(8'h00, 32'hFFFFFFFF);
        rd(8'h00, 32'hBC17FFFF, "R10 direct bits read 0 in select");
        wr(8'h00, 32'h0000FFFF);

        // R3: rising only on line 2
        ext_in[2] = 1'b1;
        wait_edges(3);
        rd(8'h0C, 32'h4, "R3 rising pending line 2");
        rd(8'h10, 32'h0, "R3 falling pending untouched");
        ext_in[2] = 1'b0;
        wait_edges(3);
        rd(8'h10, 32'h0, "R3 falling edge ignored");

        // R5: write-one-to-clear
        wr(8'h0C, 32'h0);
        rd(8'h0C, 32'h4, "R5 zero write keeps bit");
        wr(8'h0C, 32'h4);
        rd(8'h0C, 32'h0, "R5 one write clears bit");

        // R4: falling only on line 72 (bank2 bit8)
        ext_in[72] = 1'b1;
        wait_edges(3);
        rd(8'h4C, 32'h0, "R4 rising ignored on falling-only line");
        ext_in[72] = 1'b0;
        wait_edges(3);
        rd(8'h50, 32'h100, "R4 falling pending line 72");
        wr(8'h50, 32'h100);
        rd(8'h50, 32'h0, "R5 falling pending cleared");

        // R4: both edges on line 32 (bank1 bit0)
        ext_in[32] = 1'b1;
        wait_edges(3);
        rd(8'h2C, 32'h1, "R4 both-edge rising pending");
        rd(8'h30, 32'h0, "R4 both-edge falling not yet");
        ext_in[32] = 1'b0;
        wait_edges(3);
        rd(8'h30, 32'h1, "R4 both-edge falling pending");

        // R8: masking
        push(SRC_IRQ, 1, 32'h0, "R8 masked pending gives no irq");
        wr(8'h90, 32'h1);
        push(SRC_IRQ, 1, 32'h1, "R8 unmasked pending raises irq");
        wr(8'h2C, 32'h1);
        push(SRC_IRQ, 1, 32'h1, "R8 irq held by falling pending");
        wr(8'h30, 32'h1);
        push(SRC_IRQ, 1, 32'h0, "R8 irq drops when nothing pending");

        // R7: software trigger on line 64
        wr(8'h48, 32'h1);
        rd(8'h4C, 32'h1, "R7 trigger sets rising pending");
        rd(8'h48, 32'h0, "R7 trigger offset reads 0");
        push(SRC_IRQ, 2, 32'h0, "R8 bank2 masked");
        wr(8'h4C, 32'h1);

        // R9: event pulse on line 3
        wr(8'h84, 32'h8);
        ext_in[3] = 1'b1;
        wait_edges(3);
        push(SRC_EVT, 0, 32'h8, "R9 event pulse line 3");
        push(SRC_IRQ, 0, 32'h0, "R9 event independent of irq mask");
        wait_edges(1);
        push(SRC_EVT, 0, 32'h0, "R9 event lasts one cycle");
        ext_in[5] = 1'b1;
        wait_edges(3);
        push(SRC_EVT, 0, 32'h0, "R9 no event without event mask");
        wr(8'h0C, 32'h28);
        rd(8'h0C, 32'h0, "R5 clear lines 3 and 5");

        // R10: direct lines
        ext_in[19] = 1'b1;
        wait_edges(1);
        push(SRC_IRQ, 0, 32'h0, "R10 direct not yet through synchroniser");
        wait_edges(1);
        push(SRC_IRQ, 0, 32'h00080000, "R10 direct follows input");
        rd(8'h0C, 32'h0, "R10 direct has no pending");
        wr(8'h08, 32'h00080000);
        rd(8'h0C, 32'h0, "R10 trigger ignored on direct");
        ext_in[19] = 1'b0;
        wait_edges(2);
        push(SRC_IRQ, 0, 32'h0, "R10 direct follows low");
        ext_in[70] = 1'b1;
        wait_edges(2);
        push(SRC_IRQ, 2, 32'h40, "R10 direct line 70 unmasked");

        // R6: edge beats a same-cycle clear on line 4
        ext_in[4] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = 8'h0C;
        bus_wdata = 32'h10;
        @(posedge clk);
        @(negedge clk);
        bus_we    = 1'b0;
        rd(8'h0C, 32'h10, "R6 edge wins over clear");
        wr(8'h0C, 32'h10);

        // R11: unmapped offsets
        rd(8'h14, 32'h0, "R11 unmapped 0x14 reads 0");
        rd(8'h60, 32'h0, "R11 unmapped 0x60 reads 0");
        rd(8'h88, 32'h0, "R11 unmapped 0x88 reads 0");
        rd(8'hB0, 32'h0, "R11 unmapped 0xB0 reads 0");
        wr(8'h14, 32'hFFFFFFFF);
        wr(8'h60, 32'hFFFFFFFF);
        wr(8'hB4, 32'hFFFFFFFF);
        wr(8'h8C, 32'hFFFFFFFF);
        rd(8'h00, 32'h0000FFFF, "R11 select unchanged by unmapped writes");
        rd(8'h80, 32'h0, "R11 mask unchanged by unmapped writes");
        rd(8'h84, 32'h8, "R11 event mask unchanged by unmapped writes");
        rd(8'h0C, 32'h0, "R11 pending unchanged by unmapped writes");

        @(negedge clk);
        #1;
        done = 1;
        summary();
    end

endmodule